// File: doc/BRIEF.md
# Three-Phase Sine-Triangle PWM Generator

This block turns an externally supplied phase angle into gate commands for a three-leg voltage-source inverter. From a 16-bit phase word it derives three sine samples 120 degrees apart through a quarter-wave lookup. Each sample is scaled by a modulation index and centred on half of the carrier range. The result is compared against one shared up/down triangle carrier. Every leg drives an upper and a lower switch command that are complements of each other.

The phase normally comes from a grid-tracking loop elsewhere on the chip; the block never advances the phase itself. A bipolar option drives the second leg from the negated reference of the first leg, so that the first two legs give a line voltage that swings both ways. New references, the carrier peak and the mode are taken only at the carrier valley, so that no period is cut part-way through.

Top module: `spwm_gen`

## Requirements
- R1: While rst_ni is low and straight after reset, carrier_o is 0, every hi_o bit is 0 and every lo_o bit is 1.
- R2: carrier_o runs 0,1,...,P,P-1,...,1,0 and moves by exactly one step per clock, so one period is 2P cycles. P is peak_i sampled on the clock edge where carrier_o is 0, with values below 2 raised to 2. The reset value of P is 2.
- R3: A leg phase word w selects sector k = w[15:10]. The signed sine sample is s = round(255*sin((k+0.5)*2*pi/64)), rounded half away from zero.
- R4: In three-phase mode leg 0 uses phase_i, leg 1 uses phase_i-21845 and leg 2 uses phase_i+21845. Both sums wrap modulo 65536.
- R5: The modulation index is m = min(mod_i, 256), where 256 means full scale. The reference of a leg is ref = floor(P*(65536 + s*m)/131072).
- R6: hi_o[k] is 1 exactly when the held reference of leg k is greater than carrier_o. lo_o[k] is always the inverse of hi_o[k].
- R7: References, peak and mode are loaded only on the edge where carrier_o is 0. Changes to the inputs at any other time leave the outputs unchanged until the next valley.
- R8: With bipolar_i set at the valley, leg 1 uses -s of leg 0 instead of its own shifted sample. Legs 0 and 2 are unaffected.
- R9: With m = 0, every leg reference is floor(P/2), which gives a duty of one half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| phase_i | input | 16 | Phase word of leg 0, full circle = 65536 |
| mod_i | input | 9 | Modulation index, 256 = unity, larger values clamp |
| peak_i | input | 12 | Carrier peak count |
| bipolar_i | input | 1 | Leg 1 takes the negated leg 0 reference |
| carrier_o | output | 12 | Triangle carrier value |
| hi_o | output | 3 | Upper switch command per leg |
| lo_o | output | 3 | Lower switch command per leg |

## Verification
A wrong carrier direction or peak shows up on carrier_o within one clock, and the gate edges in the same period move with it. A reference that is loaded at the wrong time, or scaled or looked up wrongly, shows up as a gate edge at the wrong carrier value. This happens at the latest when the carrier next crosses that reference, which is within one carrier period of the load. The bench runs a behavioural model of the carrier and of the references, built on real-valued sine. It compares carrier_o, hi_o and lo_o on every clock while the phase, the index, the peak and the mode are swept.

// File: rtl/spwm_pkg.sv
package spwm_pkg;
  localparam int SIN_W = 8;   // sine magnitude bits, amplitude 255
  localparam int QAW   = 4;   // quarter-wave address bits

  // round(255*sin((i+0.5)*pi/32)), i = 0..15
  function automatic logic [SIN_W-1:0] quarter_sine(input logic [QAW-1:0] idx);
    logic [SIN_W-1:0] v;
    case (idx)
      4'd0:  v = 8'd13;
      4'd1:  v = 8'd37;
      4'd2:  v = 8'd62;
      4'd3:  v = 8'd86;
      4'd4:  v = 8'd109;
      4'd5:  v = 8'd131;
      4'd6:  v = 8'd152;
      4'd7:  v = 8'd171;
      4'd8:  v = 8'd189;
      4'd9:  v = 8'd205;
      4'd10: v = 8'd219;
      4'd11: v = 8'd231;
      4'd12: v = 8'd240;
      4'd13: v = 8'd247;
      4'd14: v = 8'd252;
      default: v = 8'd255;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/spwm_sine_lut.sv
module spwm_sine_lut
  import spwm_pkg::*;
(
  input  logic [QAW+1:0]          sector_i,
  output logic signed [SIN_W:0]   sine_o
);
  logic [1:0]       quad;
  logic [QAW-1:0]   idx, addr;
  logic [SIN_W-1:0] mag;

  always_comb begin
    quad   = sector_i[QAW+1:QAW];
    idx    = sector_i[QAW-1:0];
    addr   = quad[0] ? ~idx : idx;          // mirror in quadrants 1 and 3
    mag    = quarter_sine(addr);
    sine_o = quad[1] ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
  end
endmodule

// File: rtl/spwm_ref_scale.sv
module spwm_ref_scale
  import spwm_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int MOD_W = 9
) (
  input  logic signed [SIN_W:0] sine_i,
  input  logic [MOD_W-1:0]      mod_i,
  input  logic [CNT_W-1:0]      peak_i,
  output logic [CNT_W-1:0]      ref_o
);
  localparam int PROD_W = SIN_W + MOD_W + 2;
  localparam int SH     = SIN_W + MOD_W;
  localparam logic signed [PROD_W-1:0] BIAS = PROD_W'(1) << (SH - 1);

  logic signed [PROD_W-1:0] prod, biased;
  logic [SH-1:0]            level;
  logic [SH+CNT_W-1:0]      full;

  always_comb begin
    prod   = sine_i * $signed({1'b0, mod_i});
    biased = prod + BIAS;                    // non-negative by range
    level  = biased[SH-1:0];
    full   = level * peak_i;
    ref_o  = full[SH+CNT_W-1:SH];
  end
endmodule

// File: rtl/spwm_carrier.sv
module spwm_carrier #(
  parameter int CNT_W  = 12,
  parameter int PK_MIN = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] peak_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] peak_o,
  output logic [CNT_W-1:0] load_o,
  output logic             valley_o
);
  localparam logic [CNT_W-1:0] MIN_PK = CNT_W'(PK_MIN);

  logic [CNT_W-1:0] cnt_q, pk_q;
  logic             up_q;

  assign load_o   = (peak_i < MIN_PK) ? MIN_PK : peak_i;
  assign valley_o = (cnt_q == '0);
  assign cnt_o    = cnt_q;
  assign peak_o   = pk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      pk_q  <= MIN_PK;
      up_q  <= 1'b1;
    end else if (valley_o) begin
      pk_q  <= load_o;
      cnt_q <= CNT_W'(1);
      up_q  <= 1'b1;
    end else if (up_q) begin
      if (cnt_q < pk_q) begin
        cnt_q <= cnt_q + 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
        up_q  <= 1'b0;
      end
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/spwm_gen.sv
module spwm_gen
  import spwm_pkg::*;
#(
  parameter int PH_W  = 16,
  parameter int MOD_W = 9,
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PH_W-1:0]  phase_i,
  input  logic [MOD_W-1:0] mod_i,
  input  logic [CNT_W-1:0] peak_i,
  input  logic             bipolar_i,
  output logic [CNT_W-1:0] carrier_o,
  output logic [2:0]       hi_o,
  output logic [2:0]       lo_o
);
  localparam int LEGS = 3;
  localparam logic [PH_W-1:0]  THIRD = PH_W'((64'd1 << PH_W) / 3);
  localparam logic [MOD_W-1:0] UNITY = MOD_W'(1) << (MOD_W - 1);

  logic [CNT_W-1:0]       cnt, pk_q, pk_load;
  logic                   valley;
  logic [MOD_W-1:0]       mod_c;
  logic [PH_W-1:0]        leg_ph [LEGS];
  logic signed [SIN_W:0]  sine   [LEGS];
  logic signed [SIN_W:0]  sine_s [LEGS];
  logic [CNT_W-1:0]       ref_d  [LEGS];
  logic [LEGS*CNT_W-1:0]  ref_q;

  spwm_carrier #(.CNT_W(CNT_W), .PK_MIN(2)) u_carrier (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .peak_i   (peak_i),
    .cnt_o    (cnt),
    .peak_o   (pk_q),
    .load_o   (pk_load),
    .valley_o (valley)
  );

  assign mod_c = (mod_i > UNITY) ? UNITY : mod_i;

  // leg phases: a, a-120, a+120
  assign leg_ph[0] = phase_i;
  assign leg_ph[1] = phase_i - THIRD;
  assign leg_ph[2] = phase_i + THIRD;

  for (genvar k = 0; k < LEGS; k++) begin : g_leg
    spwm_sine_lut u_lut (
      .sector_i (leg_ph[k][PH_W-1 -: QAW+2]),
      .sine_o   (sine[k])
    );

    if (k == 1) begin : g_sel_bip
      assign sine_s[k] = bipolar_i ? -sine[0] : sine[k];
    end else begin : g_sel_dir
      assign sine_s[k] = sine[k];
    end

    spwm_ref_scale #(.CNT_W(CNT_W), .MOD_W(MOD_W)) u_scale (
      .sine_i (sine_s[k]),
      .mod_i  (mod_c),
      .peak_i (pk_load),
      .ref_o  (ref_d[k])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      ref_q[k*CNT_W +: CNT_W] <= '0;
      else if (valley)  ref_q[k*CNT_W +: CNT_W] <= ref_d[k];
    end

    assign hi_o[k] = ref_q[k*CNT_W +: CNT_W] > cnt;
    assign lo_o[k] = ~hi_o[k];
  end

  assign carrier_o = cnt;
endmodule

// File: rtl/spwm_gen_chk.sv
module spwm_gen_chk #(
  parameter int CNT_W = 12
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [CNT_W-1:0]   cnt_i,
  input logic [CNT_W-1:0]   pk_i,
  input logic [3*CNT_W-1:0] refs_i
);
  assert_carrier_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= pk_i);

  assert_peak_min_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pk_i >= CNT_W'(2));

  assert_carrier_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (cnt_i == $past(cnt_i) + 1'b1) || (cnt_i == $past(cnt_i) - 1'b1));

  assert_peak_turn_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == pk_i) |=> (cnt_i == $past(cnt_i) - 1'b1));

  assert_valley_rise_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == '0) |=> (cnt_i == CNT_W'(1)));

  assert_ref_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cnt_i) != '0) |-> $stable(refs_i));
endmodule

bind spwm_gen spwm_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .cnt_i  (carrier_o),
  .pk_i   (pk_q),
  .refs_i (ref_q)
);

// File: tb/spwm_gen_test.sv
`timescale 1ns/1ps
module spwm_gen_test;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic [15:0] phase_i;
  logic [8:0]  mod_i;
  logic [11:0] peak_i;
  logic        bipolar_i;
  logic [11:0] carrier_o;
  logic [2:0]  hi_o, lo_o;

  int total = 0;
  int bad   = 0;
  string cur = "R1";

  // behavioural model state
  int m_cnt, m_up, m_peak;
  int m_ref [3];

  always #4 clk = ~clk;

  spwm_gen uut (
    .clk_i(clk), .rst_ni(rst_ni), .phase_i(phase_i), .mod_i(mod_i),
    .peak_i(peak_i), .bipolar_i(bipolar_i), .carrier_o(carrier_o),
    .hi_o(hi_o), .lo_o(lo_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int sine_of(input int ph);
    int  k;
    real x;
    k = (ph >> 10) & 63;
    x = 255.0 * $sin((k + 0.5) * 2.0 * 3.14159265358979 / 64.0);
    return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
  endfunction

  function automatic int level(input int s, input int p);
    int m;
    m = (mod_i > 256) ? 256 : int'(mod_i);
    return (p * (65536 + s * m)) >>> 17;
  endfunction

  task automatic model_step();
    int s0, s1, s2, ph;
    if (!rst_ni) begin
      m_cnt = 0; m_up = 1; m_peak = 2;
      foreach (m_ref[i]) m_ref[i] = 0;
    end else if (m_cnt == 0) begin
      m_peak = (peak_i < 2) ? 2 : int'(peak_i);
      ph = int'(phase_i);
      s0 = sine_of(ph);
      s1 = bipolar_i ? -s0 : sine_of((ph - 21845) & 65535);
      s2 = sine_of((ph + 21845) & 65535);
      m_ref[0] = level(s0, m_peak);
      m_ref[1] = level(s1, m_peak);
      m_ref[2] = level(s2, m_peak);
      m_cnt = 1; m_up = 1;
    end else if (m_up == 1) begin
      if (m_cnt < m_peak) m_cnt++;
      else begin m_cnt--; m_up = 0; end
    end else begin
      m_cnt--;
    end
  endtask

  task automatic compare();
    int exp_hi;
    exp_hi = 0;
    for (int k = 0; k < 3; k++) if (m_ref[k] > m_cnt) exp_hi |= (1 << k);
    check(int'(carrier_o) == m_cnt, {"R2 carrier/", cur}, carrier_o, m_cnt);
    check(int'(hi_o) == exp_hi, {"R6 upper/", cur}, hi_o, exp_hi);
    check(int'(lo_o) == (~exp_hi & 7), {"R6 lower/", cur}, lo_o, ~exp_hi & 7);
  endtask

  task automatic cycle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      model_step();
      compare();
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #(8 * 150000);
    check(1'b0, "watchdog", 0, 1);
    summary();
    $finish;
  end

  initial begin
    rst_ni = 1'b0; phase_i = '0; mod_i = '0; peak_i = 12'd10; bipolar_i = 1'b0;
    cur = "R1";
    cycle(3);
    check(carrier_o == 12'd0, "R1 carrier", carrier_o, 0);
    check(hi_o == 3'b000, "R1 upper", hi_o, 0);
    check(lo_o == 3'b111, "R1 lower", lo_o, 7);
    rst_ni = 1'b1;

    // zero index: half duty on all legs
    cur = "R9"; phase_i = 16'd12345; peak_i = 12'd10;
    cycle(60);

    // every sector at full index, three-phase spacing
    cur = "R3 R4 R5"; mod_i = 9'd256; peak_i = 12'd300;
    for (int k = 0; k < 64; k++) begin
      phase_i = 16'(k * 1024 + 7);
      cycle(602);
    end

    // index clamp above unity and a partial index
    cur = "R5 clamp"; mod_i = 9'd511; peak_i = 12'd200; phase_i = 16'd5000;
    cycle(500);
    mod_i = 9'd100;
    cycle(500);

    // inputs moving every clock: only valley samples count
    cur = "R7";
    peak_i = 12'd64;
    for (int i = 0; i < 700; i++) begin
      phase_i = phase_i + 16'd777;
      mod_i   = 9'((i * 37) % 300);
      peak_i  = (i % 50 == 0) ? 12'(40 + i % 90) : peak_i;
      bipolar_i = (i % 129) > 64;
      cycle(1);
    end
    bipolar_i = 1'b0;

    // peak clamp and the widest carrier
    cur = "R2 min"; mod_i = 9'd200; peak_i = 12'd0;
    cycle(20);
    peak_i = 12'd1;
    cycle(20);
    cur = "R2 max"; peak_i = 12'd4095; phase_i = 16'd40000;
    cycle(8200);

    // bipolar pair on legs 0 and 1
    cur = "R8"; bipolar_i = 1'b1; peak_i = 12'd120; mod_i = 9'd230;
    for (int k = 0; k < 8; k++) begin
      phase_i = 16'(k * 8192 + 300);
      cycle(242);
    end

    summary();
    $finish;
  end
endmodule